// File: doc/BRIEF.md
# DMA Channel Transfer-Mode Controller

This block is the per-channel core of a DMA engine. It keeps a base and a current copy of a 16-bit transfer address and a 16-bit word count. After every completed transfer it moves the address by one, up or down as configured, and lowers the count by one. It also decides, cycle by cycle, whether the channel keeps its service or gives it up. Bus cycle timing, arbitration between channels and chaining of controllers are handled elsewhere. The surrounding logic pulses `xfer_i` once per finished transfer and uses `active_o` as the channel's claim on the bus.

Three service policies share the one datapath. Single mode gives up after each transfer. Block mode runs until the process ends, whatever the request line does. Demand mode runs while the request stays high and pauses when it drops, keeping its place. An end of process is either the count wrapping from 0000h to FFFFh (terminal count) or an external end-of-process input. It ends the service in every mode. If reload is enabled, it copies the base registers back into the current registers. If reload is not enabled, it masks the channel.

Top module: `dma_chan_ctl`

## Requirements
- R1: A write with `prog_we_i` high loads `prog_data_i` into both the base and the current copy of one register in the same cycle. `prog_sel_i`=0 selects the address and `prog_sel_i`=1 selects the word count. Both registers are 16 bits wide.
- R2: Each transfer strobe accepted during a service lowers the current count by one. It raises the current address by one when `dir_down_i`=0 and lowers it by one when `dir_down_i`=1.
- R3: A transfer accepted while the current count is 0000h wraps the count to FFFFh. It also sets `tc_o`, which stays set until `tc_clr_i` is pulsed; a set in the same cycle wins over the clear.
- R4: At an end of process, with `autoinit_i`=1, the current address and count are reloaded from their base copies and `mask_o` is left unchanged. With `autoinit_i`=0, `mask_o` is set and the registers keep their values.
- R5: In single mode (`mode_i`=2'b01) the service ends after one transfer. If `dreq_i` is still high, a new service starts one idle cycle later.
- R6: In block mode (`mode_i`=2'b10, and 2'b11 behaves the same) the service continues when `dreq_i` falls and ends only at an end of process.
- R7: In demand mode (`mode_i`=2'b00), `dreq_i` going low ends the service without an end of process. The current address and count are kept and are not reloaded, even with `autoinit_i`=1.
- R8: `eop_ext_i` high during a service ends that service in any mode and does not change `tc_o`. Every end of process, internal or external, gives exactly one cycle of `eop_o` in the cycle after it.
- R9: On reset the registers are 0000h, the channel is idle, `tc_o` is 0 and `mask_o` is 1. `mask_clr_i` clears the mask, and `mask_set_i` or an end-of-process set wins over the clear. An idle channel starts a service one cycle after it sees `dreq_i` high with `mask_o`=0, and never starts while masked.
- R10: `xfer_i` and `eop_ext_i` have no effect while the channel is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| prog_we_i | input | 1 | Register write strobe |
| prog_sel_i | input | 1 | 0 = address, 1 = word count |
| prog_data_i | input | 16 | Write data |
| mode_i | input | 2 | 00 demand, 01 single, 10/11 block |
| dir_down_i | input | 1 | 1 = address counts down |
| autoinit_i | input | 1 | Reload from base at end of process |
| mask_set_i | input | 1 | Set channel mask |
| mask_clr_i | input | 1 | Clear channel mask |
| tc_clr_i | input | 1 | Clear terminal-count status |
| dreq_i | input | 1 | Request level from the device |
| xfer_i | input | 1 | One transfer completed this cycle |
| eop_ext_i | input | 1 | External end of process |
| cur_addr_o | output | 16 | Current address |
| cur_count_o | output | 16 | Current word count |
| active_o | output | 1 | Channel holds a service |
| tc_o | output | 1 | Terminal-count status |
| eop_o | output | 1 | One-cycle end-of-process pulse |
| mask_o | output | 1 | Channel mask bit |

## Verification
The bench drives the count through zero to the FFFFh wrap. A design that fired terminal count on reaching zero would stop one transfer early and show the wrong count. It checks that a demand-mode pause keeps the address and count even with reload enabled, where a faulty design would rewind to the base values. It also checks that block mode ignores a dropped request, where a faulty design would release early. Further cases are the single-mode idle gap before a restart, external end of process leaving the status bit alone, and strobes while idle, which a faulty design would count.

// File: rtl/dma_chan_pkg.sv
// Shared types for the DMA channel controller.
package dma_chan_pkg;
    typedef enum logic [1:0] {
        MODE_DEMAND = 2'b00,
        MODE_SINGLE = 2'b01,
        MODE_BLOCK  = 2'b10,
        MODE_BLOCK2 = 2'b11
    } xfer_mode_e;
endpackage

// File: rtl/dma_step_reg.sv
// Base/current register pair with a one-step counter.
// Assumes at most one of wr_i, reload_i, step_i matters per cycle;
// priority is write, then reload, then step.
module dma_step_reg #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_i,
    input  logic [W-1:0] wr_data_i,
    input  logic         reload_i,
    input  logic         step_i,
    input  logic         down_i,
    output logic [W-1:0] cur_o
);
    localparam logic [W-1:0] ONE = W'(1);

    logic [W-1:0] base_q;
    logic [W-1:0] cur_q;

    // Base copy changes only on a software write.
    always_ff @(posedge clk) begin
        if (!rst_n)    base_q <= '0;
        else if (wr_i) base_q <= wr_data_i;
    end

    // Current copy: write, reload from base, or step by one.
    always_ff @(posedge clk) begin
        if (!rst_n)        cur_q <= '0;
        else if (wr_i)     cur_q <= wr_data_i;
        else if (reload_i) cur_q <= base_q;
        else if (step_i)   cur_q <= down_i ? cur_q - ONE : cur_q + ONE;
    end

    assign cur_o = cur_q;

    a_r1_write_both: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i |=> cur_o == $past(wr_data_i));
    a_r2_step_one: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !wr_i && !reload_i) |=>
        cur_o == ($past(down_i) ? $past(cur_o) - ONE : $past(cur_o) + ONE));
    a_r4_reload_base: assert property (@(posedge clk) disable iff (!rst_n)
        (reload_i && !wr_i) |=> cur_o == $past(base_q));
endmodule

// File: rtl/dma_svc_ctl.sv
// Service policy for one channel: start, continue or release under
// demand, single or block mode; terminal count, end of process,
// reload request and channel mask. Assumes cnt_zero_i reflects the
// current count in the same cycle.
module dma_svc_ctl
    import dma_chan_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  xfer_mode_e mode_i,
    input  logic       autoinit_i,
    input  logic       dreq_i,
    input  logic       xfer_i,
    input  logic       eop_ext_i,
    input  logic       cnt_zero_i,
    input  logic       mask_set_i,
    input  logic       mask_clr_i,
    input  logic       tc_clr_i,
    output logic       active_o,
    output logic       step_o,
    output logic       reload_o,
    output logic       tc_o,
    output logic       eop_o,
    output logic       mask_o
);
    logic active_q, tc_q, eop_q, mask_q;
    logic tc_hit, eop_evt, svc_end, start;
    logic is_single, is_demand;

    // Decode the policy and the end-of-service conditions.
    always_comb begin
        is_single = (mode_i == MODE_SINGLE);
        is_demand = (mode_i == MODE_DEMAND);
        step_o    = active_q & xfer_i;
        tc_hit    = step_o & cnt_zero_i;
        eop_evt   = tc_hit | (active_q & eop_ext_i);
        svc_end   = eop_evt | (step_o & is_single)
                  | (active_q & is_demand & ~dreq_i);
        reload_o  = eop_evt & autoinit_i;
        start     = ~active_q & dreq_i & ~mask_q;
    end

    // Service ownership flag.
    always_ff @(posedge clk) begin
        if (!rst_n) active_q <= 1'b0;
        else        active_q <= start | (active_q & ~svc_end);
    end

    // Sticky terminal-count status; set beats clear.
    always_ff @(posedge clk) begin
        if (!rst_n) tc_q <= 1'b0;
        else        tc_q <= tc_hit | (tc_q & ~tc_clr_i);
    end

    // One-cycle end-of-process pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) eop_q <= 1'b0;
        else        eop_q <= eop_evt;
    end

    // Channel mask: set by software or by a non-reloading end of process.
    always_ff @(posedge clk) begin
        if (!rst_n) mask_q <= 1'b1;
        else        mask_q <= (eop_evt & ~autoinit_i) | mask_set_i
                            | (mask_q & ~mask_clr_i);
    end

    assign active_o = active_q;
    assign tc_o     = tc_q;
    assign eop_o    = eop_q;
    assign mask_o   = mask_q;

    a_r3_tc_on_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (active_o && xfer_i && cnt_zero_i) |=> (tc_o && eop_o));
    a_r4_mask_on_eop: assert property (@(posedge clk) disable iff (!rst_n)
        (active_o && eop_ext_i && !autoinit_i) |=> mask_o);
    a_r5_single_once: assert property (@(posedge clk) disable iff (!rst_n)
        (active_o && xfer_i && mode_i == MODE_SINGLE) |=> !active_o);
    a_r6_block_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (active_o && mode_i == MODE_BLOCK && !xfer_i && !eop_ext_i)
        |=> active_o);
    a_r7_demand_pause: assert property (@(posedge clk) disable iff (!rst_n)
        (active_o && mode_i == MODE_DEMAND && !dreq_i) |=> !active_o);
    a_r8_eop_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        eop_o |=> !eop_o);
    a_r9_masked_stays_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!active_o && mask_o) |=> !active_o);
    a_r10_idle_no_eop: assert property (@(posedge clk) disable iff (!rst_n)
        !active_o |=> !eop_o);
endmodule

// File: rtl/dma_chan_ctl.sv
// Top of one DMA channel: two stepping register pairs (address and
// word count) and the service policy. Assumes xfer_i pulses once per
// completed bus transfer and only while the channel owns the bus.
module dma_chan_ctl
    import dma_chan_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         prog_we_i,
    input  logic         prog_sel_i,
    input  logic [W-1:0] prog_data_i,
    input  logic [1:0]   mode_i,
    input  logic         dir_down_i,
    input  logic         autoinit_i,
    input  logic         mask_set_i,
    input  logic         mask_clr_i,
    input  logic         tc_clr_i,
    input  logic         dreq_i,
    input  logic         xfer_i,
    input  logic         eop_ext_i,
    output logic [W-1:0] cur_addr_o,
    output logic [W-1:0] cur_count_o,
    output logic         active_o,
    output logic         tc_o,
    output logic         eop_o,
    output logic         mask_o
);
    localparam int NREG    = 2;
    localparam int IDX_ADR = 0;
    localparam int IDX_CNT = 1;

    logic [W-1:0] cur_v [NREG];
    logic         step, reload;
    xfer_mode_e   mode;

    assign mode = xfer_mode_e'(mode_i);

    // One register pair per index; only the address honours direction.
    for (genvar g = 0; g < NREG; g++) begin : g_reg
        logic down;
        if (g == IDX_ADR) begin : g_adr
            assign down = dir_down_i;
        end else begin : g_cnt
            assign down = 1'b1;
        end
        dma_step_reg #(.W(W)) reg_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_i      (prog_we_i && (prog_sel_i == (g == IDX_CNT))),
            .wr_data_i (prog_data_i),
            .reload_i  (reload),
            .step_i    (step),
            .down_i    (down),
            .cur_o     (cur_v[g])
        );
    end

    dma_svc_ctl svc_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_i     (mode),
        .autoinit_i (autoinit_i),
        .dreq_i     (dreq_i),
        .xfer_i     (xfer_i),
        .eop_ext_i  (eop_ext_i),
        .cnt_zero_i (cur_v[IDX_CNT] == '0),
        .mask_set_i (mask_set_i),
        .mask_clr_i (mask_clr_i),
        .tc_clr_i   (tc_clr_i),
        .active_o   (active_o),
        .step_o     (step),
        .reload_o   (reload),
        .tc_o       (tc_o),
        .eop_o      (eop_o),
        .mask_o     (mask_o)
    );

    assign cur_addr_o  = cur_v[IDX_ADR];
    assign cur_count_o = cur_v[IDX_CNT];
endmodule

// File: tb/dma_chan_ctl_tb_top.sv
// Scoreboard bench: the driver queues expected output snapshots,
// the monitor pops and compares them against the ports.
`timescale 1ns/1ps
module dma_chan_ctl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        prog_we = 0, prog_sel = 0;
    logic [15:0] prog_data = '0;
    logic [1:0]  mode = 2'b00;
    logic        dir_down = 0, autoinit = 0;
    logic        mask_set = 0, mask_clr = 0, tc_clr = 0;
    logic        dreq = 0, xfer = 0, eop_ext = 0;
    logic [15:0] cur_addr, cur_count;
    logic        active, tc, eop, mask;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    typedef struct {
        string       tag;
        logic [15:0] addr;
        logic [15:0] cnt;
        logic        act, tcb, eopb, msk;
    } exp_t;
    exp_t scb_q[$];
    event chk_ev;

    always #5 clk = ~clk;

    dma_chan_ctl dut_i (
        .clk(clk), .rst_n(rst_n), .prog_we_i(prog_we), .prog_sel_i(prog_sel),
        .prog_data_i(prog_data), .mode_i(mode), .dir_down_i(dir_down),
        .autoinit_i(autoinit), .mask_set_i(mask_set), .mask_clr_i(mask_clr),
        .tc_clr_i(tc_clr), .dreq_i(dreq), .xfer_i(xfer), .eop_ext_i(eop_ext),
        .cur_addr_o(cur_addr), .cur_count_o(cur_count), .active_o(active),
        .tc_o(tc), .eop_o(eop), .mask_o(mask)
    );

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic expect_now(string tag, logic [15:0] a, logic [15:0] c,
                              logic act_e, logic tc_e, logic eop_e, logic m_e);
        exp_t e;
        e.tag = tag; e.addr = a; e.cnt = c;
        e.act = act_e; e.tcb = tc_e; e.eopb = eop_e; e.msk = m_e;
        scb_q.push_back(e);
        -> chk_ev;
        #1;
    endtask

    task automatic prog(logic sel, logic [15:0] d);
        prog_we = 1; prog_sel = sel; prog_data = d;
        tick();
        prog_we = 0;
    endtask

    // Monitor: compare every queued snapshot with the ports.
    initial begin
        forever begin
            @(chk_ev);
            while (scb_q.size() > 0) begin
                exp_t e;
                e = scb_q.pop_front();
                checks++;
                if (cur_addr !== e.addr || cur_count !== e.cnt ||
                    active !== e.act || tc !== e.tcb || eop !== e.eopb ||
                    mask !== e.msk) begin
                    fails++;
                    $display("FAIL %s: got addr=%h cnt=%h act=%b tc=%b eop=%b mask=%b exp addr=%h cnt=%h act=%b tc=%b eop=%b mask=%b",
                        e.tag, cur_addr, cur_count, active, tc, eop, mask,
                        e.addr, e.cnt, e.act, e.tcb, e.eopb, e.msk);
                end
            end
        end
    end

    // Watchdog.
    initial begin
        #2000000;
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: got timeout exp completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    // Driver.
    initial begin
        tick(); tick();
        rst_n = 1;
        tick();
        expect_now("R9 reset", 16'h0000, 16'h0000, 0, 0, 0, 1);

        prog(1'b0, 16'h1000);
        prog(1'b1, 16'h0002);
        expect_now("R1 write base+current", 16'h1000, 16'h0002, 0, 0, 0, 1);

        dreq = 1; tick(); dreq = 0; tick();
        expect_now("R9 masked no start", 16'h1000, 16'h0002, 0, 0, 0, 1);

        mode = 2'b10; dir_down = 0; autoinit = 0;
        mask_clr = 1; tick(); mask_clr = 0;
        expect_now("R9 mask clear", 16'h1000, 16'h0002, 0, 0, 0, 0);

        xfer = 1; eop_ext = 1; tick(); xfer = 0; eop_ext = 0;
        expect_now("R10 idle ignores", 16'h1000, 16'h0002, 0, 0, 0, 0);

        dreq = 1; tick();
        expect_now("R9 start", 16'h1000, 16'h0002, 1, 0, 0, 0);
        dreq = 0; xfer = 1; tick();
        expect_now("R6 block keeps R2 up", 16'h1001, 16'h0001, 1, 0, 0, 0);
        tick();
        expect_now("R2 second step", 16'h1002, 16'h0000, 1, 0, 0, 0);
        tick();
        expect_now("R3 wrap tc R4 mask", 16'h1003, 16'hFFFF, 0, 1, 1, 1);
        xfer = 0; tick();
        expect_now("R8 eop one cycle", 16'h1003, 16'hFFFF, 0, 1, 0, 1);

        prog(1'b0, 16'h2000);
        prog(1'b1, 16'h0001);
        mode = 2'b01; dir_down = 1; autoinit = 1;
        tc_clr = 1; mask_clr = 1; tick(); tc_clr = 0; mask_clr = 0;
        expect_now("R3 tc clear", 16'h2000, 16'h0001, 0, 0, 0, 0);
        dreq = 1; tick();
        expect_now("R5 single start", 16'h2000, 16'h0001, 1, 0, 0, 0);
        xfer = 1; tick(); xfer = 0;
        expect_now("R5 single release R2 down", 16'h1FFF, 16'h0000, 0, 0, 0, 0);
        tick();
        expect_now("R5 restart", 16'h1FFF, 16'h0000, 1, 0, 0, 0);
        xfer = 1; tick(); xfer = 0; dreq = 0;
        expect_now("R4 autoinit reload", 16'h2000, 16'h0001, 0, 1, 1, 0);
        tick();

        prog(1'b0, 16'h3000);
        prog(1'b1, 16'h0005);
        mode = 2'b00; dir_down = 0; autoinit = 0;
        tc_clr = 1; tick(); tc_clr = 0;
        dreq = 1; tick();
        xfer = 1; tick(); xfer = 0;
        expect_now("R7 demand step", 16'h3001, 16'h0004, 1, 0, 0, 0);
        dreq = 0; tick();
        expect_now("R7 demand pause keeps", 16'h3001, 16'h0004, 0, 0, 0, 0);
        dreq = 1; tick();
        xfer = 1; tick(); xfer = 0;
        expect_now("R7 demand resume", 16'h3002, 16'h0003, 1, 0, 0, 0);
        eop_ext = 1; tick(); eop_ext = 0; dreq = 0;
        expect_now("R8 ext eop R4 mask", 16'h3002, 16'h0003, 0, 0, 1, 1);
        tick();
        expect_now("R8 pulse ends", 16'h3002, 16'h0003, 0, 0, 0, 1);

        prog(1'b0, 16'h4000);
        prog(1'b1, 16'h0003);
        autoinit = 1;
        mask_clr = 1; tick(); mask_clr = 0;
        dreq = 1; tick();
        xfer = 1; tick(); xfer = 0;
        dreq = 0; tick();
        expect_now("R7 pause no reload", 16'h4001, 16'h0002, 0, 0, 0, 0);
        dreq = 1; tick();
        eop_ext = 1; tick(); eop_ext = 0; dreq = 0;
        expect_now("R8 ext eop reload R4", 16'h4000, 16'h0003, 0, 0, 1, 0);

        mask_set = 1; mask_clr = 1; tick(); mask_set = 0; mask_clr = 0;
        expect_now("R9 set beats clear", 16'h4000, 16'h0003, 0, 0, 0, 1);

        tick();
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule